// File: doc/BRIEF.md
# Configuration Header Clock-Ratio Detector

This block sits in the path of a 32-bit configuration image stream that uses valid/ready handshakes. Every word passes straight through to the downstream side. There is no added latency, and the ready signal runs combinationally from the sink back to the source. While the words pass, the block counts the words that complete a handshake. It takes an encryption flag from one fixed header word and a compression flag from a later fixed header word. It then joins the two flags with the selected bus width to form a 2-bit clock-to-data ratio code.

The downstream loader starts a new image by pulsing `start_i`. This returns the word count to zero and clears any earlier result. Once the compression word has been accepted, `ratio_valid_o` goes high and `ratio_o` holds the code. Both stay fixed until the next start pulse. The width input can change after that point without affecting the code. If the image ends, marked by `s_last` on an accepted word, before the compression word has been seen, `short_err_o` goes high. In that case no ratio is reported.

Top module: `hdr_ratio_detect`

## Requirements
- R1: The downstream outputs `m_valid`, `m_data` and `m_last` equal `s_valid`, `s_data` and `s_last` in the same cycle. `s_ready` equals `m_ready` in the same cycle.
- R2: After reset, `ratio_valid_o`, `short_err_o` and `ratio_o` are all 0.
- R3: The image counts as encrypted when bits [3:2] of word 69 are nonzero. Words are counted from 0, and a word counts only when `s_valid` and `m_ready` are both 1 in a cycle.
- R4: The image counts as compressed when bit 1 of word 229 is 0.
- R5: The ratio code uses 0 for x1, 1 for x2, 2 for x4 and 3 for x8. An image that is neither encrypted nor compressed gets 0 at either width. Otherwise the base code is 2 when the image is compressed and 1 when it is only encrypted, and the code is one higher when `wide_i` is 1 (32-bit width).
- R6: `ratio_valid_o` and the new `ratio_o` appear in the cycle after word 229 is accepted. Before that, `ratio_valid_o` is 0.
- R7: Once valid, `ratio_o` and `ratio_valid_o` hold until a start pulse. This holds through idle cycles and through changes on `wide_i`.
- R8: If `s_last` is accepted on a word with index below 229, `short_err_o` goes to 1 in the next cycle and no ratio is reported. If the last word is word 229 or any later word, no error is raised.
- R9: A start pulse with no accepted word in the same cycle clears `ratio_valid_o`, `short_err_o` and `ratio_o` by the next cycle.
- R10: A cycle in which `s_valid` is 1 but `m_ready` is 0 does not advance the word count.
- R11: Words after word 229 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New-image pulse |
| wide_i | input | 1 | 1 selects the 32-bit configuration width, 0 the 16-bit width |
| s_valid | input | 1 | Upstream word valid |
| s_ready | output | 1 | Upstream ready |
| s_data | input | 32 | Upstream word |
| s_last | input | 1 | Upstream final word of the image |
| m_valid | output | 1 | Downstream word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 32 | Downstream word |
| m_last | output | 1 | Downstream final word of the image |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_valid_o | output | 1 | Ratio code is available |
| short_err_o | output | 1 | Image ended before the header was complete |

## Verification
The hardest case is to make the block sample the right word while back-pressure and source gaps move the index in time. A word that is stalled, or one of its neighbours, could be taken for word 69 or word 229. The stimulus therefore throttles both `s_valid` and `m_ready` at random on every cycle, and it places different random data in stalled cycles than in the word that is finally accepted. The bench also covers images that end one word short, images that end exactly on word 229, and longer images whose tail words would flip the flags if they were sampled.

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LO  = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [1:0]        ratio_o,
  output logic              ratio_valid_o,
  output logic              short_err_o
);
  localparam int CNT_W = $clog2(CMP_IDX + 2);
  localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);
  localparam logic [CNT_W-1:0] SAT_AT = CNT_W'(CMP_IDX + 1);

  assign m_valid = s_valid;
  assign m_data  = s_data;
  assign m_last  = s_last;
  assign s_ready = m_ready;

  logic [CNT_W-1:0] idx_q, idx_base;
  logic             enc_q, done_q, err_q;
  logic [1:0]       ratio_q, ratio_next;
  logic             xfer, live, cmp_now;

  assign xfer     = s_valid & m_ready;
  assign live     = start_i | (~done_q & ~err_q);
  assign idx_base = start_i ? '0 : idx_q;
  assign cmp_now  = ~s_data[CMP_BIT];

  always_comb begin
    if (!enc_q && !cmp_now) ratio_next = 2'd0;
    else ratio_next = (cmp_now ? 2'd2 : 2'd1) + {1'b0, wide_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      enc_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ratio_q <= 2'd0;
    end else begin
      if (start_i) begin
        idx_q   <= '0;
        enc_q   <= 1'b0;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
        ratio_q <= 2'd0;
      end
      if (xfer && live) begin
        if (idx_base != SAT_AT) idx_q <= idx_base + 1'b1;
        if (idx_base == ENC_AT) enc_q <= |s_data[ENC_LO+1:ENC_LO];
        if (idx_base == CMP_AT) begin
          done_q  <= 1'b1;
          ratio_q <= ratio_next;
        end
        if (s_last && idx_base < CMP_AT) err_q <= 1'b1;
      end
    end
  end

  assign ratio_o       = ratio_q;
  assign ratio_valid_o = done_q;
  assign short_err_o   = err_q;

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid_o && !start_i) |=> (ratio_valid_o && $stable(ratio_o)));

  a_r6_valid_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid_o) |-> $past(s_valid && m_ready));

  a_r8_error_excludes_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_err_o && ratio_valid_o));

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !(s_valid && m_ready)) |=> (!ratio_valid_o && !short_err_o && ratio_o == 2'd0));

  a_r10_stall_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && m_ready) && !start_i) |=> $stable(idx_q));
endmodule

// File: tb/hdr_ratio_detect_bench.sv
module hdr_ratio_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, wide_i = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, m_valid, m_last, ratio_valid_o, short_err_o;
  logic [31:0] m_data;
  logic [1:0] ratio_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  hdr_ratio_detect u_hdr_ratio_detect (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .ratio_o(ratio_o), .ratio_valid_o(ratio_valid_o), .short_err_o(short_err_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_ratio(input logic [1:0] encf, input logic cbit, input logic w);
    logic e, c;
    e = (encf != 2'b00);
    c = (cbit == 1'b0);
    if (!e && !c) return 2'd0;
    return (c ? 2'd2 : 2'd1) + {1'b0, w};
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1; s_valid = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check("R9 valid cleared", ratio_valid_o, 0);
    check("R9 error cleared", short_err_o, 0);
    check("R9 ratio cleared", ratio_o, 0);
  endtask

  // Sends one image; runs from a negedge and ends on a negedge.
  task automatic run_image(input int len, input logic [1:0] encf, input logic cbit, input logic w);
    logic [1:0] er;
    logic [31:0] word;
    bit acc;
    er = exp_ratio(encf, cbit, w);
    wide_i = w;
    for (int k = 0; k < len; k++) begin
      word = $urandom;
      if (k == 69) word[3:2] = encf;
      if (k == 229) word[1] = cbit;
      acc = 0;
      while (!acc) begin
        s_valid = ($urandom % 4) != 0;
        m_ready = ($urandom % 4) != 0;
        // R10: stalled cycles carry different data than the accepted word
        s_data = (s_valid && m_ready) ? word : ~word;
        s_last = (k == len - 1);
        #1;
        if (k % 37 == 0) begin
          check("R1 data", m_data, s_data);
          check("R1 valid/last/ready", {m_valid, m_last, s_ready}, {s_valid, s_last, m_ready});
        end
        @(posedge clk);
        acc = s_valid && m_ready;
        @(negedge clk);
      end
      if (k == 228) check("R6 not valid before word 229", ratio_valid_o, 0);
      if (k == 229) begin
        check("R6 valid after word 229", ratio_valid_o, 1);
        check("R5 R3 R4 ratio code", ratio_o, er);
      end
    end
    s_valid = 1'b0; s_last = 1'b0;
    check("R8 short error", short_err_o, len < 230);
    if (len >= 230) begin
      check("R11 ratio after tail words", ratio_o, er);
      wide_i = ~w;
      repeat (5) @(negedge clk);
      check("R7 hold valid", ratio_valid_o, 1);
      check("R7 hold ratio", ratio_o, er);
    end else begin
      check("R8 no ratio on short image", ratio_valid_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset valid", ratio_valid_o, 0);
    check("R2 reset error", short_err_o, 0);
    check("R2 reset ratio", ratio_o, 0);
    rst_n = 1'b1;
    void'($urandom(32'd7));
    pulse_start();
    for (int c = 0; c < 8; c++) begin
      run_image(230, c[2] ? 2'(1 + c % 3) : 2'b00, c[1], c[0]);
      pulse_start();
    end
    run_image(229, 2'b11, 1'b0, 1'b1);   // R8 one word short
    pulse_start();
    run_image(1, 2'b00, 1'b0, 1'b0);
    pulse_start();
    run_image(70, 2'b10, 1'b0, 1'b1);
    pulse_start();
    run_image(300, 2'b01, 1'b1, 1'b1);   // R11 long tail
    pulse_start();
    for (int r = 0; r < 8; r++) begin
      run_image(200 + $urandom % 80, 2'($urandom), 1'($urandom), 1'($urandom));
      pulse_start();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule